// File: doc/BRIEF.md
# Instruction Fetch Protection Checker

This block watches every instruction fetch issued by a processor core and decides whether code may run from the fetched address. When a fetch breaks a protection rule, it raises a one-cycle freeze request together with a 2-bit violation code. The rest of the system acts on that request; this block does not stop anything itself.

Two rule sets are built in, and a mode input picks one. In first-generation mode the top of the archive address space is forbidden. Its lower edge is set by a programmable limit. Even-address fetches into that region are counted, and the fourth one locks the checker into a freezing state until reset. In second-generation mode three rules apply. Low RAM has a per-4 KB page execute-disable bitmap. High RAM has a single execute-disable control. Flash has a programmable execute boundary: fetches at or above it are refused.

Top module: `fetch_guard`

## Requirements
- R1: After reset `freeze` is 0, `vcode` is 0 and the internal strike count is 0, so the first three even-address strikes after reset do not freeze.
- R2: In first-generation mode (`genSel`=0) the forbidden window is `0x390000 + archLimit*0x10000` up to and including `0x3FFFFF`. A fetch outside that window never freezes. If the lower edge lies above `0x3FFFFF`, the window is empty.
- R3: In first-generation mode each even-address fetch inside the window adds one to the strike count. The fetch that brings the count to 4 freezes with `vcode` = 2'b01.
- R4: An odd-address fetch inside the window leaves the strike count unchanged.
- R5: The strike count saturates at 4. From then on, every window fetch of either parity freezes with code 2'b01, until reset clears the count.
- R6: In second-generation mode (`genSel`=1), a fetch below `0x040000` freezes with code 2'b10 when bit `fetchAddr[17:12]` of `pageXd` is 1.
- R7: In second-generation mode, a fetch in `0x040000`..`0x1FFFFF` freezes with code 2'b10 when `hiRamXd` is 1, and never freezes otherwise.
- R8: In second-generation mode, a fetch in `0x210000`..`0x1FFFFF + romBanks*0x10000` freezes with code 2'b11 when the address is at or above `0x210000 + FLASH_BASE + flashBound*0x10000`.
- R9: Only the selected mode's rules are evaluated. Second-generation fetches never change the strike count and never give code 2'b01. First-generation fetches ignore `pageXd`, `hiRamXd`, `romBanks` and `flashBound`. Second-generation fetches in `0x200000`..`0x20FFFF`, and at or above the flash window, never freeze.
- R10: `freeze` is high only in the cycle after a clock edge that sampled `fetchValid`=1 on a violating fetch. `vcode` is 0 whenever `freeze` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| genSel | input | 1 | Rule set: 0 first generation, 1 second generation |
| fetchValid | input | 1 | An instruction fetch is presented this cycle |
| fetchAddr | input | ADDR_W (24) | Fetch byte address |
| archLimit | input | LIMIT_W (3) | Archive limit, in 64 KB steps above 0x390000 |
| romBanks | input | ROM_W (6) | Flash size in 64 KB banks |
| pageXd | input | PAGES (64) | Execute-disable bit per 4 KB low-RAM page |
| hiRamXd | input | 1 | Execute-disable for high RAM |
| flashBound | input | BOUND_W (8) | Flash execute boundary, in 64 KB steps |
| freeze | output | 1 | One-cycle freeze request |
| vcode | output | 2 | Violation code: 0 none, 1 archive, 2 RAM, 3 flash |

## Verification
The only hidden state is the strike count. A count that is wrong, that fails to saturate, or that odd fetches or second-generation traffic disturb shows up at the ports on the next even fetch into the archive window. Such a fetch either freezes one strike early or late, or fails to freeze after saturation, one cycle after the strobe. The bench therefore moves strikes between modes and parities, and resets in the middle of a sequence, then watches where the first freeze falls. Decode errors in the address windows appear in the first cycle after a fetch at a window edge, so the bench probes each edge and the address one below it.

// File: rtl/fg_pkg.sv
package fg_pkg;

  // Violation codes; the numeric values are visible at the vcode port.
  typedef enum logic [1:0] {
    VC_NONE    = 2'd0,
    VC_ARCHIVE = 2'd1,
    VC_RAM     = 2'd2,
    VC_FLASH   = 2'd3
  } vcodeE;

  // Region decode results handed from the datapath to the control.
  typedef struct packed {
    logic inArch;      // inside first-generation forbidden window
    logic evenAddr;    // fetch address bit 0 is clear
    logic ramPageHit;  // low RAM fetch on an execute-disabled page
    logic ramHighHit;  // high RAM fetch with high RAM execute-disabled
    logic flashHit;    // flash fetch at or above the execute boundary
  } regionT;

  // Strobes from the control back to the datapath output stage.
  typedef struct packed {
    logic  fire;
    vcodeE code;
  } strobeT;

  // Fixed address-map anchors.
  localparam logic [23:0] ARCH_BASE  = 24'h390000;
  localparam logic [23:0] ARCH_TOP   = 24'h3FFFFF;
  localparam logic [23:0] HIRAM_TOP  = 24'h1FFFFF;
  localparam logic [23:0] FLASH_LO   = 24'h210000;
  localparam int          BANK_SH    = 16;  // 64 KB step
  localparam int          PAGE_SH    = 12;  // 4 KB page

endpackage

// File: rtl/fg_datapath.sv
module fg_datapath
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LIMIT_W    = 3,
  parameter int ROM_W      = 6,
  parameter int BOUND_W    = 8,
  parameter int PAGES      = 64,
  parameter int FLASH_BASE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic [LIMIT_W-1:0] archLimit,
  input  logic [ROM_W-1:0]   romBanks,
  input  logic [PAGES-1:0]   pageXd,
  input  logic               hiRamXd,
  input  logic [BOUND_W-1:0] flashBound,
  input  strobeT             stb,
  output regionT             region,
  output logic               freeze,
  output logic [1:0]         vcode
);

  // Wide compare width so that sums never wrap.
  localparam int CW         = ADDR_W + 3;
  localparam int PAGE_IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam logic [CW-1:0] LOW_RAM_END = CW'(PAGES) << PAGE_SH;

  logic [CW-1:0] addrW;
  logic [CW-1:0] archLo;
  logic [CW-1:0] flashHi;
  logic [CW-1:0] flashThr;
  logic [PAGE_IDX_W-1:0] pageIdx;
  logic          pageBit;

  assign addrW    = CW'(fetchAddr);
  assign archLo   = CW'(ARCH_BASE) + (CW'(archLimit) << BANK_SH);
  assign flashHi  = CW'(HIRAM_TOP) + (CW'(romBanks) << BANK_SH);
  assign flashThr = CW'(FLASH_LO) + CW'(FLASH_BASE) + (CW'(flashBound) << BANK_SH);
  assign pageIdx  = fetchAddr[PAGE_SH +: PAGE_IDX_W];

  // Page bit select; a single page needs no index.
  generate
    if (PAGES > 1) begin : gMultiPage
      assign pageBit = pageXd[pageIdx];
    end else begin : gOnePage
      assign pageBit = pageXd[0];
    end
  endgenerate

  logic inLowRam;
  logic inHighRam;
  logic inFlash;

  always_comb begin
    inLowRam  = addrW < LOW_RAM_END;
    inHighRam = !inLowRam && (addrW <= CW'(HIRAM_TOP));
    inFlash   = (addrW >= CW'(FLASH_LO)) && (addrW <= flashHi);

    region.inArch     = (addrW >= archLo) && (addrW <= CW'(ARCH_TOP));
    region.evenAddr   = !fetchAddr[0];
    region.ramPageHit = inLowRam && pageBit;
    region.ramHighHit = inHighRam && hiRamXd;
    region.flashHit   = inFlash && (addrW >= flashThr);
  end

  // Output register: pulse for one cycle per violating fetch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeze <= 1'b0;
      vcode  <= VC_NONE;
    end else if (stb.fire) begin
      freeze <= 1'b1;
      vcode  <= stb.code;
    end else begin
      freeze <= 1'b0;
      vcode  <= VC_NONE;
    end
  end

endmodule

// File: rtl/fg_control.sv
module fg_control
  import fg_pkg::*;
#(
  parameter int STRIKES = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   fetchValid,
  input  logic   genSel,
  input  regionT region,
  output strobeT stb
);

  localparam int CNT_W = $clog2(STRIKES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STRIKES);

  logic [CNT_W-1:0] crashCnt;
  logic [CNT_W-1:0] cntNext;
  logic             archStep;
  logic             gen2Step;

  always_comb begin
    archStep = fetchValid && !genSel && region.inArch;
    gen2Step = fetchValid && genSel;

    cntNext = crashCnt;
    if (archStep && region.evenAddr && (crashCnt != CNT_MAX))
      cntNext = crashCnt + 1'b1;

    stb.fire = 1'b0;
    stb.code = VC_NONE;
    if (archStep && (cntNext == CNT_MAX)) begin
      stb.fire = 1'b1;
      stb.code = VC_ARCHIVE;
    end else if (gen2Step && (region.ramPageHit || region.ramHighHit)) begin
      stb.fire = 1'b1;
      stb.code = VC_RAM;
    end else if (gen2Step && region.flashHit) begin
      stb.fire = 1'b1;
      stb.code = VC_FLASH;
    end
  end

  // Strike counter: saturates, cleared only by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crashCnt <= '0;
    else       crashCnt <= cntNext;
  end

endmodule

// File: rtl/fetch_guard.sv
module fetch_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LIMIT_W    = 3,
  parameter int ROM_W      = 6,
  parameter int BOUND_W    = 8,
  parameter int PAGES      = 64,
  parameter int FLASH_BASE = 0,
  parameter int STRIKES    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               genSel,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic [LIMIT_W-1:0] archLimit,
  input  logic [ROM_W-1:0]   romBanks,
  input  logic [PAGES-1:0]   pageXd,
  input  logic               hiRamXd,
  input  logic [BOUND_W-1:0] flashBound,
  output logic               freeze,
  output logic [1:0]         vcode
);

  regionT region;
  strobeT stb;

  fg_datapath #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .ROM_W(ROM_W),
    .BOUND_W(BOUND_W), .PAGES(PAGES), .FLASH_BASE(FLASH_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .archLimit(archLimit),
    .romBanks(romBanks), .pageXd(pageXd), .hiRamXd(hiRamXd),
    .flashBound(flashBound), .stb(stb), .region(region),
    .freeze(freeze), .vcode(vcode)
  );

  fg_control #(.STRIKES(STRIKES)) uCtl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .genSel(genSel),
    .region(region), .stb(stb)
  );

endmodule

// File: rtl/fetch_guard_chk.sv
module fetch_guard_chk #(
  parameter int ADDR_W  = 24,
  parameter int LIMIT_W = 3,
  parameter int ROM_W   = 6,
  parameter int BOUND_W = 8,
  parameter int PAGES   = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               genSel,
  input logic               fetchValid,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic [LIMIT_W-1:0] archLimit,
  input logic [ROM_W-1:0]   romBanks,
  input logic [PAGES-1:0]   pageXd,
  input logic               hiRamXd,
  input logic [BOUND_W-1:0] flashBound,
  input logic               freeze,
  input logic [1:0]         vcode
);

  localparam int CW = ADDR_W + 3;
  logic [CW-1:0] addrW;
  logic [CW-1:0] lowArch;
  assign addrW   = CW'(fetchAddr);
  assign lowArch = CW'(24'h390000) + (CW'(archLimit) << 16);

  // R10: quiet code whenever no freeze
  a_r10_code_idle: assert property (@(posedge clk) disable iff (!rstN)
    !freeze |-> vcode == 2'd0);
  // R10: a freeze always carries a code
  a_r10_code_set: assert property (@(posedge clk) disable iff (!rstN)
    freeze |-> vcode != 2'd0);
  // R10: no strobe, no freeze next cycle
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !freeze);
  // R9: second generation never reports the archive code
  a_r9_gen2_code: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && genSel |=> vcode != 2'd1);
  // R9: first generation reports only the archive code
  a_r9_gen1_code: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !genSel |=> (vcode == 2'd0 || vcode == 2'd1));
  // R9: gap between high RAM and flash is always executable
  a_r9_gap: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && genSel && addrW >= CW'(24'h200000) && addrW < CW'(24'h210000)
    |=> !freeze);
  // R2: below the archive window nothing freezes
  a_r2_below_window: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !genSel && addrW < lowArch |=> !freeze);
  // R6: disabled low RAM page freezes with RAM code
  a_r6_page_hit: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && genSel && addrW < (CW'(PAGES) << 12) && pageXd[fetchAddr[12 +: $clog2(PAGES)]]
    |=> freeze && vcode == 2'd2);
  // R7: high RAM with execute disabled freezes with RAM code
  a_r7_high_ram: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && genSel && hiRamXd && addrW >= (CW'(PAGES) << 12) && addrW <= CW'(24'h1FFFFF)
    |=> freeze && vcode == 2'd2);

endmodule

bind fetch_guard fetch_guard_chk #(
  .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .ROM_W(ROM_W),
  .BOUND_W(BOUND_W), .PAGES(PAGES)
) uChk (.*);

// File: tb/fetch_guard_tb_top.sv
module fetch_guard_tb_top;

  localparam int FLASH_BASE = 0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        genSel = 1'b0;
  logic        fetchValid = 1'b0;
  logic [23:0] fetchAddr = '0;
  logic [2:0]  archLimit = '0;
  logic [5:0]  romBanks = '0;
  logic [63:0] pageXd = '0;
  logic        hiRamXd = 1'b0;
  logic [7:0]  flashBound = '0;
  logic        freeze;
  logic [1:0]  vcode;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  string prevReq = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  fetch_guard dut_i (
    .clk(clk), .rstN(rstN), .genSel(genSel), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .archLimit(archLimit), .romBanks(romBanks),
    .pageXd(pageXd), .hiRamXd(hiRamXd), .flashBound(flashBound),
    .freeze(freeze), .vcode(vcode)
  );

  // Behavioural reference model.
  int strikes = 0;
  bit expFreeze = 0;
  int expCode = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strikes = 0; expFreeze = 0; expCode = 0;
    end else begin
      longint a, lo, hi, thr;
      bit f; int c;
      f = 0; c = 0; a = longint'(fetchAddr);
      if (fetchValid) begin
        if (!genSel) begin
          lo = 64'h390000 + longint'(archLimit) * 65536;
          if (a >= lo && a <= 64'h3FFFFF) begin
            if (a % 2 == 0 && strikes < 4) strikes++;
            if (strikes >= 4) begin f = 1; c = 1; end
          end
        end else begin
          hi  = 64'h1FFFFF + longint'(romBanks) * 65536;
          thr = 64'h210000 + FLASH_BASE + longint'(flashBound) * 65536;
          if (a < 64'h40000) begin
            if (pageXd[a / 4096]) begin f = 1; c = 2; end
          end else if (a <= 64'h1FFFFF) begin
            if (hiRamXd) begin f = 1; c = 2; end
          end else if (a >= 64'h210000 && a <= hi && a >= thr) begin
            f = 1; c = 3;
          end
        end
      end
      expFreeze = f; expCode = c;
    end
  end

  task automatic compareNow();
    checks++;
    if (freeze !== expFreeze || int'(vcode) != expCode) begin
      errors++;
      $display("FAIL %s: freeze=%0b vcode=%0d, expected freeze=%0b vcode=%0d (t=%0t)",
               prevReq, freeze, vcode, expFreeze, expCode, $time);
    end
  endtask

  // Compare previous cycle's result, then drive the next stimulus.
  task automatic cyc(input bit v, input bit g, input logic [23:0] a, input string req);
    @(negedge clk);
    compareNow();
    prevReq = curReq;
    curReq = req;
    fetchValid = v; genSel = g; fetchAddr = a;
  endtask

  task automatic fetch1(input logic [23:0] a, input string req);
    cyc(1'b1, 1'b0, a, req);
  endtask
  task automatic fetch2(input logic [23:0] a, input string req);
    cyc(1'b1, 1'b1, a, req);
  endtask
  task automatic idle(input string req);
    cyc(1'b0, genSel, fetchAddr, req);
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    fetchValid = 0; rstN = 0; prevReq = req; curReq = req;
    @(negedge clk);
    compareNow();  // reset state
    rstN = 1;
  endtask

  // Watchdog
  int cycCount = 0;
  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 150000) begin
      errors++;
      $display("FAIL R10 watchdog: run did not end, actual %0d cycles, expected below 150000", cycCount);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset("R1");
    idle("R1");

    // R2/R3: limit 2 -> window starts 0x3B0000
    archLimit = 3'd2;
    fetch1(24'h3AFFFE, "R2");   // just below window
    fetch1(24'h3B0000, "R3");   // strike 1
    fetch1(24'h3B0001, "R4");   // odd: no change
    fetch1(24'h3C1234, "R3");   // strike 2
    fetch1(24'h3FFFFF, "R4");   // odd top edge
    fetch1(24'h3FFFFE, "R3");   // strike 3
    idle("R3");
    fetch1(24'h3D0000, "R3");   // strike 4 -> freeze
    fetch1(24'h3D0001, "R5");   // saturated, odd -> freeze
    fetch1(24'h3D0002, "R5");   // saturated even -> freeze
    fetch1(24'h400000, "R2");   // above window
    fetch1(24'h100000, "R2");
    idle("R10");

    // R5: reset clears the count
    doReset("R5");
    fetch1(24'h3E0000, "R1");
    fetch1(24'h3E0002, "R1");
    fetch1(24'h3E0004, "R1");
    idle("R1");

    // R9: gen2 traffic in archive range does not touch the count
    pageXd = 64'hFFFF_FFFF_FFFF_FFFF; hiRamXd = 1; romBanks = 6'd32; flashBound = 8'd0;
    fetch2(24'h3E0006, "R9");
    fetch2(24'h3E0008, "R9");
    archLimit = 3'd0;
    fetch1(24'h000000, "R9");   // gen1 ignores gen2 config
    fetch1(24'h100000, "R9");
    fetch1(24'h300000, "R9");
    fetch1(24'h390000, "R3");   // strike 4 -> freeze
    idle("R10");

    // R2: empty window with limit 7
    doReset("R2");
    archLimit = 3'd7;
    for (int i = 0; i < 6; i++) fetch1(24'h3F0000 + 24'(i * 2), "R2");

    // R6: page bitmap
    pageXd = 64'h0;
    pageXd[5] = 1'b1; pageXd[63] = 1'b1; hiRamXd = 0;
    fetch2(24'h005000, "R6");
    fetch2(24'h004FFF, "R6");
    fetch2(24'h005FFF, "R6");
    fetch2(24'h03F000, "R6");
    fetch2(24'h03EFFE, "R6");
    fetch2(24'h000000, "R6");

    // R7: high RAM
    fetch2(24'h040000, "R7");
    fetch2(24'h1FFFFF, "R7");
    hiRamXd = 1;
    fetch2(24'h040000, "R7");
    fetch2(24'h1FFFFF, "R7");
    fetch2(24'h200000, "R9");   // gap
    fetch2(24'h20FFFF, "R9");

    // R8: flash boundary
    romBanks = 6'd16; flashBound = 8'd3;  // window up to 0x2FFFFF, threshold 0x240000
    fetch2(24'h210000, "R8");
    fetch2(24'h23FFFF, "R8");
    fetch2(24'h240000, "R8");
    fetch2(24'h2FFFFF, "R8");
    fetch2(24'h300000, "R9");   // beyond flash window
    flashBound = 8'd0;
    fetch2(24'h210000, "R8");
    romBanks = 6'd0;
    fetch2(24'h210000, "R8");   // empty flash window
    idle("R10");

    // Mixed pseudo-random traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      archLimit = 3'($urandom_range(0, 7));
      romBanks = 6'($urandom_range(0, 63));
      flashBound = 8'($urandom_range(0, 40));
      hiRamXd = 1'($urandom_range(0, 1));
      pageXd = {$urandom(), $urandom()};
      if (i % 500 == 0) doReset("R1");
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
          24'($urandom_range(0, 24'h5FFFFF)), "R10");
      if (i % 3 == 0) fetch1(24'($urandom_range(24'h390000, 24'h3FFFFF)), "R5");
    end
    idle("R10");
    idle("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule